// File: doc/BRIEF.md
# Carrier-Compare Drive PWM with Peak-Current Cut

This block produces the single drive-enable line that gates the high-side switches of a three-phase commutation stage. A triangle carrier is built from the system clock by a prescaler and a step counter. The enable is high while the carrier sits below a digital control word. The control word is captured only at each carrier period boundary, so a change never splits a period.

The same enable is also gated by an active-low external pulse input, so a host can set the duty with its own pulse train instead of the control word. To use only the pulse input, tie the control word to full scale. To use only the carrier comparison, hold the pulse input low.

A digital current-sense flag from an off-chip comparator feeds a peak limiter. The flag must stay high for a programmable number of consecutive clocks before it counts, which rejects the short spikes that diode reverse recovery causes just after turn-on. Once a trip qualifies, drive stays cut until the next carrier period begins.

The carrier frequency is `clk / (2 * (CAR_HI - 1 - CAR_LO) * PRE_DIV)`. The defaults give about 22 kHz from a 50 MHz clock. Valid settings span 15 kHz to 50 kHz.

Top module: `drive_pwm_limiter`

## Requirements
- R1: The carrier holds each value for PRE_DIV clocks and visits CAR_LO, CAR_LO+1, ..., CAR_HI-1, then CAR_HI-2, ..., CAR_LO+1, then starts again at CAR_LO. A period is 2*(CAR_HI-1-CAR_LO)*PRE_DIV clocks. Period boundaries fall on every multiple of that count of rising edges after reset release.
- R2: Drive is on while the carrier value is strictly less than the captured control word. For CAR_LO < ctl < CAR_HI this gives 2*(ctl-CAR_LO)-1 carrier steps of drive per period.
- R3: A control word at or below CAR_LO gives 0% duty. A control word at or above CAR_HI gives 100% duty.
- R4: The control word is captured only at a period boundary. A change made mid-period has no effect until the clock after the next boundary.
- R5: The pulse input is active low and passes through a two-flop synchronizer that resets high. Pulse high means drive off. Pulse low lets the other terms drive.
- R6: The enable is the registered AND of three terms: the carrier comparison, the inverted synchronized pulse input, and the inverted limiter flag.
- R7: A current-sense high lasting fewer than BLANK_CYC consecutive clocks has no effect on drive.
- R8: A current-sense high lasting BLANK_CYC or more consecutive clocks sets the limiter flag. Drive then stays off for the rest of that carrier period, even after the sense input falls.
- R9: The limiter flag clears at the period boundary, and drive resumes on the first clock after it.
- R10: Reset forces the enable low and the captured control word to zero, so drive stays off through the first carrier period after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ctlValue | input | CW | Digital duty control word |
| pulseInN | input | 1 | Active-low external PWM pulse input (asynchronous) |
| senseIn | input | 1 | Over-current flag from the current comparator (asynchronous) |
| drvEn | output | 1 | Drive enable toward the commutation stage |

## Verification
The hardest behaviour to reach from the ports is the limiter latch: its effect only shows if the sense pulse ends well before the carrier boundary. The bench tracks period phase by counting rising edges from reset release. It starts each sense pulse a fixed number of clocks after a boundary, then samples the enable in the middle of the period, at its end, and on the first clock of the next period. The pulse lengths straddle the blanking threshold: one clock below it, and exactly at it. The mid-period capture rule is probed the same way: the control word jumps from 0% to 100% halfway through a period.

// File: rtl/dpl_pkg.sv
package dpl_pkg;

  // Strobes issued by the carrier sequencer once per carrier step.
  typedef struct packed {
    logic stepUp;       // carrier moves up one count
    logic stepDown;     // carrier moves down one count
    logic periodStart;  // this step returns the carrier to its floor
  } carStrobe_t;

endpackage

// File: rtl/dpl_carrier_ctrl.sv
module dpl_carrier_ctrl
  import dpl_pkg::*;
#(
  parameter int PRE_DIV = 8,
  parameter int CAR_LO  = 8,
  parameter int CAR_HI  = 150
) (
  input  logic       clk,
  input  logic       rstN,
  output carStrobe_t strobe
);

  localparam int HALF  = CAR_HI - 1 - CAR_LO;
  localparam int STEPS = 2 * HALF;
  localparam int SW    = (STEPS > 2) ? $clog2(STEPS) : 1;

  logic          tick;
  logic [SW-1:0] posCnt;
  logic          lastPos;
  logic          risingHalf;

  // Prescaler: one carrier step every PRE_DIV clocks.
  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int PW = $clog2(PRE_DIV);
      logic [PW-1:0] preCnt;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          preCnt <= '0;
        end else if (preCnt == PW'(PRE_DIV - 1)) begin
          preCnt <= '0;
        end else begin
          preCnt <= preCnt + 1'b1;
        end
      end

      assign tick = (preCnt == PW'(PRE_DIV - 1));

      AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);  // R1
    end else begin : g_nopre
      assign tick = 1'b1;
    end
  endgenerate

  assign lastPos    = (posCnt == SW'(STEPS - 1));
  assign risingHalf = (posCnt < SW'(HALF));

  // Position of the carrier inside its period, in steps.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      posCnt <= '0;
    end else if (tick) begin
      posCnt <= lastPos ? '0 : posCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.stepUp      = tick &&  risingHalf;
    strobe.stepDown    = tick && !risingHalf;
    strobe.periodStart = tick &&  lastPos;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.stepUp, strobe.stepDown}));  // R1

  AST_START_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.periodStart |=> !strobe.periodStart);  // R1

endmodule

// File: rtl/dpl_compare_path.sv
module dpl_compare_path
  import dpl_pkg::*;
#(
  parameter int CW     = 8,
  parameter int CAR_LO = 8,
  parameter int CAR_HI = 150
) (
  input  logic          clk,
  input  logic          rstN,
  input  carStrobe_t    strobe,
  input  logic [CW-1:0] ctlValue,
  input  logic          pulseInN,
  input  logic          limFlag,
  output logic          drvEn
);

  localparam logic [CW-1:0] LO_V  = CW'(CAR_LO);
  localparam logic [CW-1:0] TOP_V = CW'(CAR_HI - 1);
  localparam logic [CW-1:0] HI_V  = CW'(CAR_HI);

  logic [CW-1:0] car;
  logic [CW-1:0] ctlLatched;
  logic          pulseS1;
  logic          pulseS2;
  logic          cmpOn;
  logic          drvEnQ;

  // Triangle carrier register, moved by the sequencer strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      car <= LO_V;
    end else if (strobe.periodStart) begin
      car <= LO_V;
    end else if (strobe.stepUp) begin
      car <= car + 1'b1;
    end else if (strobe.stepDown) begin
      car <= car - 1'b1;
    end
  end

  // Control word captured at the period boundary only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlLatched <= '0;
    end else if (strobe.periodStart) begin
      ctlLatched <= ctlValue;
    end
  end

  // External pulse synchronizer; resets to the off level.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseS1 <= 1'b1;
      pulseS2 <= 1'b1;
    end else begin
      pulseS1 <= pulseInN;
      pulseS2 <= pulseS1;
    end
  end

  assign cmpOn = (ctlLatched > car);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvEnQ <= 1'b0;
    end else begin
      drvEnQ <= cmpOn & ~pulseS2 & ~limFlag;
    end
  end

  assign drvEn = drvEnQ;

  AST_CAR_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (car >= LO_V) && (car <= TOP_V));  // R1

  AST_CAR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.periodStart |-> (car == LO_V + CW'(1)));  // R1

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.periodStart |=> $stable(ctlLatched));  // R4

  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    (ctlLatched <= LO_V) |=> !drvEnQ);  // R3

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rstN)
    ((ctlLatched >= HI_V) && !pulseS2 && !limFlag) |=> drvEnQ);  // R3

  AST_PULSE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    pulseS2 |=> !drvEnQ);  // R5

endmodule

// File: rtl/dpl_sense_limiter.sv
module dpl_sense_limiter #(
  parameter int BLANK_CYC = 50
) (
  input  logic clk,
  input  logic rstN,
  input  logic periodStart,
  input  logic senseIn,
  output logic limFlag
);

  localparam int QW = $clog2(BLANK_CYC + 1);
  localparam logic [QW-1:0] QMAX = QW'(BLANK_CYC);

  logic          senseS1;
  logic          senseS2;
  logic [QW-1:0] runCnt;
  logic          qualified;
  logic          flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseS1 <= 1'b0;
      senseS2 <= 1'b0;
    end else begin
      senseS1 <= senseIn;
      senseS2 <= senseS1;
    end
  end

  // Count consecutive high samples, saturating at the blanking length.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt <= '0;
    end else if (!senseS2) begin
      runCnt <= '0;
    end else if (runCnt != QMAX) begin
      runCnt <= runCnt + 1'b1;
    end
  end

  assign qualified = (runCnt == QMAX);

  // Cycle-by-cycle latch: the boundary clear wins over a trip in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= 1'b0;
    end else if (periodStart) begin
      flagQ <= 1'b0;
    end else if (qualified) begin
      flagQ <= 1'b1;
    end
  end

  assign limFlag = flagQ;

  AST_TRIP_NEEDS_SENSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(senseS2, 2));  // R7

  AST_CLEAR_AT_START: assert property (@(posedge clk) disable iff (!rstN)
    periodStart |=> !flagQ);  // R9

endmodule

// File: rtl/drive_pwm_limiter.sv
module drive_pwm_limiter
  import dpl_pkg::*;
#(
  parameter int CW        = 8,
  parameter int PRE_DIV   = 8,
  parameter int CAR_LO    = 8,
  parameter int CAR_HI    = 150,
  parameter int BLANK_CYC = 50
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] ctlValue,
  input  logic          pulseInN,
  input  logic          senseIn,
  output logic          drvEn
);

  carStrobe_t strobe;
  logic       limFlag;

  dpl_carrier_ctrl #(
    .PRE_DIV(PRE_DIV),
    .CAR_LO (CAR_LO),
    .CAR_HI (CAR_HI)
  ) i_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe)
  );

  dpl_sense_limiter #(
    .BLANK_CYC(BLANK_CYC)
  ) i_limit (
    .clk        (clk),
    .rstN       (rstN),
    .periodStart(strobe.periodStart),
    .senseIn    (senseIn),
    .limFlag    (limFlag)
  );

  dpl_compare_path #(
    .CW    (CW),
    .CAR_LO(CAR_LO),
    .CAR_HI(CAR_HI)
  ) i_path (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ctlValue(ctlValue),
    .pulseInN(pulseInN),
    .limFlag (limFlag),
    .drvEn   (drvEn)
  );

  AST_LIMIT_CUTS: assert property (@(posedge clk) disable iff (!rstN)
    limFlag |=> !drvEn);  // R8

  AST_RESET_OFF: assert property (@(posedge clk)
    !rstN |-> !drvEn);  // R10

endmodule

// File: tb/test_drive_pwm_limiter.sv
module test_drive_pwm_limiter;

  localparam int CLK_NS = 20;
  localparam int CW     = 8;
  localparam int PRE    = 2;
  localparam int LO     = 4;
  localparam int HI     = 20;
  localparam int BLANK  = 8;
  localparam int P      = 2 * (HI - 1 - LO) * PRE;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] ctl = CW'(HI);
  logic          pulseN = 1'b0;
  logic          sense = 1'b0;
  logic          drvEn;

  always #(CLK_NS / 2) clk = ~clk;

  drive_pwm_limiter #(
    .CW(CW), .PRE_DIV(PRE), .CAR_LO(LO), .CAR_HI(HI), .BLANK_CYC(BLANK)
  ) i_drive_pwm_limiter (
    .clk(clk), .rstN(rstN), .ctlValue(ctl), .pulseInN(pulseN),
    .senseIn(sense), .drvEn(drvEn)
  );

  int cyc = 0;
  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  int    qLen[$];
  int    qExp[$];
  string qTag[$];
  int    pushed = 0;
  int    done = 0;
  int    nChecks = 0;
  int    nFail = 0;
  bit    finished = 0;

  // Driver side: queue an expected count of enable-high samples.
  task automatic expectWin(input int len, input int exp, input string tag);
    qLen.push_back(len);
    qExp.push_back(exp);
    qTag.push_back(tag);
    pushed++;
  endtask

  task automatic drain();
    wait (done == pushed);
  endtask

  task automatic waitPhase(input int k);
    do @(negedge clk); while ((cyc % P) != k);
  endtask

  // Expected drive clocks per carrier period from the compare rule (R2, R3).
  function automatic int dutyOnes(input int c);
    if (c <= LO) return 0;
    if (c >= HI) return P;
    return (2 * (c - LO) - 1) * PRE;
  endfunction

  // Monitor: pops expectations and counts enable samples at falling edges.
  initial begin
    forever begin
      int len;
      int exp;
      int ones;
      string tag;
      wait (qLen.size() > 0);
      len  = qLen.pop_front();
      exp  = qExp.pop_front();
      tag  = qTag.pop_front();
      ones = 0;
      repeat (len) begin
        @(negedge clk);
        if (drvEn === 1'b1) ones++;
      end
      nChecks++;
      if (ones != exp) begin
        nFail++;
        $display("FAIL %s: actual %0d enable clocks, expected %0d", tag, ones, exp);
      end
      done++;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int vals[7] = '{0, 4, 5, 12, 19, 20, 255};

    // R10: reset state and the first period after release
    repeat (4) @(negedge clk);
    expectWin(3, 0, "R10 enable low in reset");
    drain();
    rstN = 1'b1;
    expectWin(55, 0, "R10 first period off with captured zero");
    drain();
    waitPhase(1);
    expectWin(1, 1, "R10 drive begins after first boundary");
    drain();

    // R2 and R3: duty sweep including both rails
    for (int i = 0; i < 7; i++) begin
      ctl = CW'(vals[i]);
      waitPhase(0);
      waitPhase(5);
      if (vals[i] <= LO || vals[i] >= HI)
        expectWin(P, dutyOnes(vals[i]), $sformatf("R3 rail duty ctl=%0d", vals[i]));
      else
        expectWin(P, dutyOnes(vals[i]), $sformatf("R2 compare duty ctl=%0d", vals[i]));
      drain();
    end

    // R4: mid-period change waits for the boundary
    ctl = CW'(LO);
    waitPhase(0);
    waitPhase(5);
    waitPhase(10);
    ctl = CW'(HI);
    expectWin(50, 0, "R4 mid-period change ignored");
    drain();
    expectWin(2, 2, "R4 new word applied after boundary");
    drain();

    // R5: external pulse input
    pulseN = 1'b1;
    repeat (4) @(negedge clk);
    expectWin(P, 0, "R5 pulse high holds drive off");
    drain();
    expectWin(120, 30, "R5 pulse train passes low time");
    for (int r = 0; r < 3; r++) begin
      pulseN = 1'b0;
      repeat (10) @(negedge clk);
      pulseN = 1'b1;
      repeat (30) @(negedge clk);
    end
    drain();
    pulseN = 1'b0;
    repeat (4) @(negedge clk);
    expectWin(P, P, "R5 pulse low permits full drive");
    drain();

    // R7: sense pulse one clock shorter than the blanking length
    waitPhase(5);
    expectWin(40, 40, "R7 short sense pulse ignored");
    sense = 1'b1;
    repeat (BLANK - 1) @(negedge clk);
    sense = 1'b0;
    drain();

    // R8 and R9: sense pulse exactly at the blanking length
    waitPhase(5);
    sense = 1'b1;
    repeat (BLANK) @(negedge clk);
    sense = 1'b0;
    waitPhase(25);
    expectWin(5, 0, "R8 qualified sense cuts drive");
    drain();
    expectWin(30, 0, "R8 cut held to end of period");
    drain();
    expectWin(1, 1, "R9 drive resumes after boundary");
    drain();

    // R6: AND of comparison and pulse term
    ctl = CW'(12);
    pulseN = 1'b1;
    waitPhase(0);
    waitPhase(5);
    expectWin(P, 0, "R6 comparison on but pulse high gives no drive");
    drain();
    pulseN = 1'b0;
    waitPhase(5);
    expectWin(P, dutyOnes(12), "R6 comparison alone after pulse released");
    drain();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule